// File: doc/BRIEF.md
# Half-Bridge Dead-Time Gate Sequencer

This block converts a single synchronous PWM stream into a pair of gate commands for a half-bridge power stage. The high-side command follows the PWM level and the low-side command follows its inverse. Both commands are never on together: whenever the PWM level changes, the side being switched off drops first. The side being switched on then waits for a selectable number of clock cycles before it rises. The same wait applies in both switching directions.

A 4-bit thermometer-coded mode input selects the wait length. It also carries a stop code that forces both commands low, which leaves the bridge output floating. Four codes select a wait, and a higher code gives a shorter wait. With the intended 200 MHz clock, the default waits of 3, 5, 7 and 9 cycles give 15, 25, 35 and 45 ns. Any other code is treated as stop.

The mode input and the active-low undervoltage input are asynchronous and pass through two-flop synchronizers. The PWM input is synchronous to `clk` and is captured in one register. The reset `rst_n` asserts asynchronously, and the surrounding reset logic is assumed to release it synchronously.

Top module: `halfbridge_deadtime`

## Requirements
- R1: While `rst_n` is low, both gate outputs are low. After reset is released with a valid code and `uv_n` high, both outputs stay low. The side selected by `pwm_in` then rises on the (N+3)th rising clock edge after release, where N is the wait length of the selected code.
- R2: At default parameters, each mode code selects a wait of N cycles as follows: 4'b1111 gives 3, 4'b0111 gives 5, 4'b0011 gives 7 and 4'b0001 gives 9.
- R3: A change of `pwm_in` turns the conducting side off on the 2nd rising edge after the change. The opposite side turns on exactly N edges after that turn-off. This holds for both the high-to-low and the low-to-high transition.
- R4: `gate_hi` and `gate_lo` are never high in the same cycle.
- R5: A mode code of 4'b0000, or any code that is not one of the four valid codes, drives both outputs low on the 3rd rising edge after the code appears. While such a code is held, toggling `pwm_in` has no effect on the outputs.
- R6: `uv_n` low drives both outputs low on the 3rd rising edge after it falls. The outputs stay low while `uv_n` is held low.
- R7: The wait length is taken from the synchronized code only when a wait starts. A code change that arrives while a wait is counting does not alter that wait. The change takes effect at the next transition.
- R8: If `pwm_in` returns to its previous level before the wait expires, the pending turn-on is cancelled and the opposite side never rises. The side that was turned off rises again only after a complete new wait of N cycles, counted from the reversal.
- R9: When a stop code or undervoltage is removed, both outputs start low. The side selected by `pwm_in` rises on the (N+3)th edge after the release.
- R10: In steady state, `gate_hi` equals the `pwm_in` value sampled two edges earlier, and `gate_lo` equals its inverse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sequencing clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| pwm_in | input | 1 | PWM level, synchronous to clk; the high side follows it |
| mode_therm | input | 4 | Thermometer code that selects the wait length or stop |
| uv_n | input | 1 | Active-low undervoltage, asynchronous |
| gate_hi | output | 1 | High-side gate command |
| gate_lo | output | 1 | Low-side gate command |

## Verification
Two functions can fall in the same cycle: the start of a wait and a change of the wait length. In a separate case, a PWM reversal can coincide with a counting wait. The bench provokes the first by changing the code one cycle after a PWM edge, so the synchronized code arrives inside the running count. It provokes the second by reversing the PWM one cycle after a change, so the reload lands where a decrement would otherwise occur. Both are judged by the exact edge on which a gate rises and by confirming that the cancelled side never rises.

// File: rtl/hbdt_pkg.sv
package hbdt_pkg;

  localparam int MODE_W = 4;

  localparam logic [MODE_W-1:0] CODE_L4 = 4'b1111;
  localparam logic [MODE_W-1:0] CODE_L3 = 4'b0111;
  localparam logic [MODE_W-1:0] CODE_L2 = 4'b0011;
  localparam logic [MODE_W-1:0] CODE_L1 = 4'b0001;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_DEAD = 2'd1,
    ST_HI   = 2'd2,
    ST_LO   = 2'd3
  } hbdt_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/hbdt_sync.sv
module hbdt_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    logic [WIDTH-1:0] r;
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= RST_VAL;
        else        r <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= RST_VAL;
        else        r <= g_stg[i-1].r;
      end
    end
  end

  assign q = g_stg[STAGES-1].r;

endmodule

// File: rtl/hbdt_mode_dec.sv
module hbdt_mode_dec
  import hbdt_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int DEAD_CYC_L4 = 3,
  parameter int DEAD_CYC_L3 = 5,
  parameter int DEAD_CYC_L2 = 7,
  parameter int DEAD_CYC_L1 = 9
) (
  input  logic [MODE_W-1:0] code,
  output logic              stop,
  output logic [CNT_W-1:0]  dead_val
);

  // Only exact thermometer codes select a wait; everything else stops.
  always_comb begin
    stop     = 1'b0;
    dead_val = CNT_W'(DEAD_CYC_L1);
    unique case (code)
      CODE_L4: dead_val = CNT_W'(DEAD_CYC_L4);
      CODE_L3: dead_val = CNT_W'(DEAD_CYC_L3);
      CODE_L2: dead_val = CNT_W'(DEAD_CYC_L2);
      CODE_L1: dead_val = CNT_W'(DEAD_CYC_L1);
      default: stop     = 1'b1;
    endcase
  end

endmodule

// File: rtl/hbdt_dead_timer.sv
module hbdt_dead_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             dec,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en = load | dec;

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/hbdt_gate_fsm.sv
module hbdt_gate_fsm
  import hbdt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_q,
  input  logic force_off,
  input  logic last,
  output logic load,
  output logic dec,
  output logic gate_hi,
  output logic gate_lo
);

  hbdt_state_e st_q, st_d;
  logic        tgt_q, tgt_d;

  always_comb begin
    st_d  = st_q;
    tgt_d = tgt_q;
    load  = 1'b0;
    dec   = 1'b0;
    if (force_off) begin
      st_d = ST_OFF;
    end else begin
      unique case (st_q)
        ST_OFF: begin
          load  = 1'b1;
          tgt_d = pwm_q;
          st_d  = ST_DEAD;
        end
        ST_HI: begin
          if (!pwm_q) begin
            load  = 1'b1;
            tgt_d = 1'b0;
            st_d  = ST_DEAD;
          end
        end
        ST_LO: begin
          if (pwm_q) begin
            load  = 1'b1;
            tgt_d = 1'b1;
            st_d  = ST_DEAD;
          end
        end
        ST_DEAD: begin
          if (pwm_q != tgt_q) begin
            load  = 1'b1;
            tgt_d = pwm_q;
          end else if (last) begin
            st_d = tgt_q ? ST_HI : ST_LO;
          end else begin
            dec = 1'b1;
          end
        end
        default: st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_OFF;
      tgt_q   <= 1'b0;
      gate_hi <= 1'b0;
      gate_lo <= 1'b0;
    end else begin
      st_q    <= st_d;
      tgt_q   <= tgt_d;
      gate_hi <= (st_d == ST_HI);
      gate_lo <= (st_d == ST_LO);
    end
  end

endmodule

// File: rtl/halfbridge_deadtime.sv
module halfbridge_deadtime
  import hbdt_pkg::*;
#(
  parameter int DEAD_CYC_L4 = 3,
  parameter int DEAD_CYC_L3 = 5,
  parameter int DEAD_CYC_L2 = 7,
  parameter int DEAD_CYC_L1 = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwm_in,
  input  logic [MODE_W-1:0] mode_therm,
  input  logic              uv_n,
  output logic              gate_hi,
  output logic              gate_lo
);

  localparam int DEAD_MAX = imax(imax(DEAD_CYC_L4, DEAD_CYC_L3),
                                 imax(DEAD_CYC_L2, DEAD_CYC_L1));
  localparam int CNT_W = $clog2(DEAD_MAX + 1);

  logic              pwm_q;
  logic [MODE_W-1:0] mode_s;
  logic              uv_s;
  logic              stop;
  logic [CNT_W-1:0]  dead_val;
  logic              load, dec, last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= pwm_in;
  end

  hbdt_sync #(.WIDTH(MODE_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_mode_sync (
    .clk(clk), .rst_n(rst_n), .d(mode_therm), .q(mode_s)
  );

  hbdt_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_uv_sync (
    .clk(clk), .rst_n(rst_n), .d(uv_n), .q(uv_s)
  );

  hbdt_mode_dec #(
    .CNT_W(CNT_W),
    .DEAD_CYC_L4(DEAD_CYC_L4), .DEAD_CYC_L3(DEAD_CYC_L3),
    .DEAD_CYC_L2(DEAD_CYC_L2), .DEAD_CYC_L1(DEAD_CYC_L1)
  ) u_dec (
    .code(mode_s), .stop(stop), .dead_val(dead_val)
  );

  hbdt_dead_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .dec(dec),
    .load_val(dead_val), .last(last)
  );

  hbdt_gate_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .pwm_q(pwm_q), .force_off(stop | ~uv_s),
    .last(last), .load(load), .dec(dec), .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

endmodule

// File: rtl/hbdt_checker.sv
module hbdt_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       pwm_in,
  input logic [3:0] mode_therm,
  input logic       uv_n,
  input logic       gate_hi,
  input logic       gate_lo
);

  p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo));

  // Depth 3 matches the shortest default wait.
  p_hi_dead_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_hi) |-> (!gate_lo && !$past(gate_lo) && !$past(gate_lo, 2) && !$past(gate_lo, 3)));

  p_lo_dead_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_lo) |-> (!gate_hi && !$past(gate_hi) && !$past(gate_hi, 2) && !$past(gate_hi, 3)));

  p_stop_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_therm == 4'b0000 && $past(mode_therm) == 4'b0000 && $past(mode_therm, 2) == 4'b0000)
    |=> (!gate_hi && !gate_lo));

  p_uv_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!uv_n && !$past(uv_n) && !$past(uv_n, 2)) |=> (!gate_hi && !gate_lo));

  p_hi_phase_r10: assert property (@(posedge clk) disable iff (!rst_n)
    gate_hi |-> $past(pwm_in, 2));

  p_lo_phase_r10: assert property (@(posedge clk) disable iff (!rst_n)
    gate_lo |-> !$past(pwm_in, 2));

endmodule

bind halfbridge_deadtime hbdt_checker u_chk (.*);

// File: tb/halfbridge_deadtime_test.sv
module halfbridge_deadtime_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pwm_in;
  logic [3:0] mode_therm;
  logic       uv_n;
  logic       gate_hi, gate_lo;

  int n_chk  = 0;
  int n_fail = 0;
  int ovl    = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  halfbridge_deadtime uut (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .mode_therm(mode_therm),
    .uv_n(uv_n), .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  always @(negedge clk) if (rst_n === 1'b1 && gate_hi && gate_lo) ovl++;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic samp();
    @(posedge clk);
    #2;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) samp();
  endtask

  task automatic set_mode(input logic [3:0] c);
    @(negedge clk);
    mode_therm = c;
    wait_cyc(4);
  endtask

  // Drive pwm and find the edge indices of turn-off and turn-on.
  task automatic measure(input logic v, output int off_k, output int on_k);
    off_k = -1;
    on_k  = -1;
    @(negedge clk);
    pwm_in = v;
    for (int k = 1; k <= 30; k++) begin
      samp();
      if (off_k < 0 && !(v ? gate_lo : gate_hi)) off_k = k;
      if (v ? gate_hi : gate_lo) begin
        on_k = k;
        break;
      end
    end
  endtask

  // Index of first rise of the chosen side after a stimulus at the last negedge.
  task automatic rise_idx(input bit hi_side, input int lim, output int idx);
    idx = -1;
    for (int k = 1; k <= lim; k++) begin
      samp();
      if (hi_side ? gate_hi : gate_lo) begin
        idx = k;
        break;
      end
    end
  endtask

  task automatic t_reset();
    int idx;
    rst_n = 1'b0; pwm_in = 1'b1; mode_therm = 4'b1111; uv_n = 1'b1;
    wait_cyc(3);
    check(!gate_hi && !gate_lo, "R1", "outputs in reset", {gate_hi, gate_lo}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    rise_idx(1'b1, 12, idx);
    check(idx == 6, "R1", "high-side rise edge after reset", idx, 6);
    check(!gate_lo, "R1", "low side after reset", gate_lo, 0);
  endtask

  task automatic t_presets();
    logic [3:0] codes [4] = '{4'b1111, 4'b0111, 4'b0011, 4'b0001};
    int         waits [4] = '{3, 5, 7, 9};
    int off_k, on_k;
    for (int i = 0; i < 4; i++) begin
      set_mode(codes[i]);
      measure(1'b0, off_k, on_k);
      check(off_k == 2, "R3", "high-side off edge", off_k, 2);
      check(on_k - off_k == waits[i], "R2", "wait high-to-low", on_k - off_k, waits[i]);
      wait_cyc(2);
      check(!gate_hi && gate_lo, "R10", "steady low phase", {gate_hi, gate_lo}, 1);
      measure(1'b1, off_k, on_k);
      check(off_k == 2, "R3", "low-side off edge", off_k, 2);
      check(on_k - off_k == waits[i], "R3", "wait low-to-high", on_k - off_k, waits[i]);
      wait_cyc(2);
      check(gate_hi && !gate_lo, "R10", "steady high phase", {gate_hi, gate_lo}, 2);
    end
  endtask

  task automatic t_latch();
    int idx, off_k, on_k;
    set_mode(4'b0001);
    @(negedge clk);
    pwm_in = 1'b0;
    samp();
    @(negedge clk);
    mode_therm = 4'b1111;
    idx = -1;
    for (int k = 2; k <= 20; k++) begin
      samp();
      if (gate_lo) begin
        idx = k;
        break;
      end
    end
    check(idx == 11, "R7", "running wait kept at 9", idx, 11);
    wait_cyc(4);
    measure(1'b1, off_k, on_k);
    check(on_k == 5, "R7", "new code used at next edge", on_k, 5);
  endtask

  task automatic t_cancel();
    int idx;
    bit lo_seen;
    set_mode(4'b0001);
    @(negedge clk);
    pwm_in = 1'b0;
    @(negedge clk);
    pwm_in = 1'b1;
    idx = -1;
    lo_seen = 0;
    for (int k = 1; k <= 16; k++) begin
      samp();
      if (gate_lo) lo_seen = 1;
      if (gate_hi && idx < 0) idx = k;
    end
    check(!lo_seen, "R8", "cancelled low side never rose", lo_seen, 0);
    check(idx == 11, "R8", "high side after full new wait", idx, 11);
  endtask

  task automatic t_shutdown();
    logic [3:0] bad [2] = '{4'b0101, 4'b1110};
    int idx;
    bit any_on;
    set_mode(4'b1111);
    @(negedge clk);
    mode_therm = 4'b0000;
    samp(); samp();
    check(gate_hi, "R5", "high side before stop lands", gate_hi, 1);
    samp();
    check(!gate_hi && !gate_lo, "R5", "stop code outputs", {gate_hi, gate_lo}, 0);
    any_on = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      pwm_in = ~pwm_in;
      samp();
      if (gate_hi || gate_lo) any_on = 1;
    end
    check(!any_on, "R5", "pwm ignored during stop", any_on, 0);
    @(negedge clk);
    pwm_in = 1'b0;
    mode_therm = 4'b1111;
    rise_idx(1'b0, 12, idx);
    check(idx == 6, "R9", "low side after stop release", idx, 6);
    for (int j = 0; j < 2; j++) begin
      wait_cyc(2);
      @(negedge clk);
      mode_therm = bad[j];
      wait_cyc(3);
      check(!gate_hi && !gate_lo, "R5", "invalid code outputs", {gate_hi, gate_lo}, 0);
      @(negedge clk);
      mode_therm = 4'b1111;
      rise_idx(1'b0, 12, idx);
      check(idx == 6, "R9", "low side after invalid code", idx, 6);
    end
  endtask

  task automatic t_uv();
    int idx;
    bit any_on;
    wait_cyc(2);
    @(negedge clk);
    uv_n = 1'b0;
    samp(); samp();
    check(gate_lo, "R6", "low side before undervoltage lands", gate_lo, 1);
    samp();
    check(!gate_hi && !gate_lo, "R6", "undervoltage outputs", {gate_hi, gate_lo}, 0);
    @(negedge clk);
    pwm_in = 1'b1;
    any_on = 0;
    for (int k = 0; k < 8; k++) begin
      samp();
      if (gate_hi || gate_lo) any_on = 1;
    end
    check(!any_on, "R6", "held low under undervoltage", any_on, 0);
    @(negedge clk);
    uv_n = 1'b1;
    rise_idx(1'b1, 12, idx);
    check(idx == 6, "R9", "high side after undervoltage release", idx, 6);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      check(ovl == 0, "R4", "overlap cycles", ovl, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    finish_run();
  end

  initial begin
    t_reset();
    t_presets();
    t_latch();
    t_cancel();
    t_shutdown();
    t_uv();
    wait_cyc(4);
    finish_run();
  end

endmodule